// File: doc/BRIEF.md
# Maskable Transmit Interrupt Status Register

This block gathers transition events from a serial-link transmitter and its data queue into one interrupt status register. Each status bit is set by a rising transition of its condition input and stays set until a processor reads it, whether or not the condition is still present. An enable register decides which set bits may pull the active-low interrupt line. A bit whose enable is clear is still recorded, so the register can be polled at any time.

A read of the status register starts with a command byte on a serial control port. The port's shifter is outside this block and delivers the decoded command as a one-cycle strobe. The read cycle ends with a separate end strobe. Events that arrive while a read cycle is open are not lost: they are held and merged in once the read ends. The bits that were returned are then cleared. The interrupt line lets go at the first falling edge of the serial port clock after the read command, so the processor sees the line drop before it finishes the read. One bit position is shared: a select input decides whether it reports a transmit underrun or a frame abort.

Top module: `irq_status_reg`

## Requirements
- R1: After power-up reset (`rst_n` low at a clock edge) or a software reset (`sw_rst_i` high at a clock edge), every status bit and every enable bit is 0, and `irq_n_o` is 1.
- R2: A 0-to-1 transition of `cond_i[k]` sets status bit k at the next clock edge. A condition held high sets the bit only once: after that bit has been cleared by a read, it stays 0 until the condition falls and rises again.
- R3: A status bit whose enable bit is 0 is still set and returned by a read, but it does not drive `irq_n_o` low.
- R4: Outside a release window (R8), `irq_n_o` is 0 exactly when some status bit and its enable bit are both 1.
- R5: A read command (`cmd_stb_i`=1, `cmd_rd_i`=1) at address `STAT_ADDR` (default 7) returns the status register on `rdata_o` from the following cycle. A read at `EN_ADDR` (default 6) returns the enable register. A write command (`cmd_rd_i`=0) at `EN_ADDR` loads `wdata_i` into the enable register. Bit k of either register belongs to event k.
- R6: When `rd_end_i` closes a status read, exactly the bits returned by that read are cleared. A bit set in the cycle of the read command itself was not returned, so it stays set.
- R7: A transition that arrives while a status read is open, up to and including the `rd_end_i` cycle, does not change the status register during the read. It sets its bit one cycle after the read ends.
- R8: After a status read command, the first falling edge of `sclk_i` releases `irq_n_o` to 1 from the next cycle. A falling edge in the command cycle itself does not count. The line stays released until the read ends.
- R9: Bit `SHARED_POS` (default 2) reports transitions of `alt_cond_i` (transmit underrun) when `sel_alt_i` is 1, and transitions of `cond_i[SHARED_POS]` (frame abort) when `sel_alt_i` is 0. A transition of the source that is not selected has no effect.
- R10: A software reset clears the enable register, so every event is masked until software writes the register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| sw_rst_i | input | 1 | Synchronous software reset, active high |
| cond_i | input | NUM_EVT | Event condition levels; bit SHARED_POS is frame abort |
| alt_cond_i | input | 1 | Transmit underrun condition level |
| sel_alt_i | input | 1 | 1: shared bit reports underrun, 0: frame abort |
| sclk_i | input | 1 | Serial port clock, already synchronised to clk |
| cmd_stb_i | input | 1 | One-cycle strobe of a decoded command byte |
| cmd_rd_i | input | 1 | 1 read, 0 write |
| cmd_addr_i | input | ADDR_W | Register address of the command |
| wdata_i | input | NUM_EVT | Write data for the enable register |
| rd_end_i | input | 1 | One-cycle strobe ending the open status read |
| rdata_o | output | NUM_EVT | Read data captured at a read command |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions take it for granted that `rd_end_i` pulses only while a status read is open and that no second status read command arrives before the open one ends. They also assume `sclk_i` is already synchronous to `clk`. The stimulus always pairs one read command with one later end strobe, and it changes the serial clock only on the falling edge of the system clock. Condition inputs are raised for one cycle and then lowered, except in the held-level case, which depends on the level staying high on purpose.

// File: rtl/irq_status_pkg.sv
// Package irq_status_pkg
// Holds the default geometry and register addresses shared by the
// interrupt status register block and its bench.
package irq_status_pkg;
    localparam int unsigned DEF_NUM_EVT    = 4;
    localparam int unsigned DEF_ADDR_W     = 3;
    localparam int unsigned DEF_STAT_ADDR  = 7;
    localparam int unsigned DEF_EN_ADDR    = 6;
    localparam int unsigned DEF_SHARED_POS = 2;
endpackage

// File: rtl/irq_edge_detect.sv
// Module irq_edge_detect
// Turns condition levels into one-cycle pulses on each 0-to-1 transition.
// Assumes the inputs are synchronous to clk. A level that is high when
// reset ends counts as a transition.
module irq_edge_detect #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] level_q;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_i;
    end

    // One pulse per bit for each rising transition.
    always_comb rise_o = level_i & ~level_q;

    // R2: a pulse cannot repeat in the following cycle on the same bit
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_event_latch.sv
// Module irq_event_latch
// Sticky status bits with clear-on-read and a holding register for events
// that arrive while a status read is open. Assumes rd_end_i only comes
// while a read is open. A start request during an open read is ignored.
module irq_event_latch #(
    parameter int unsigned NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst_i,
    input  logic [NUM_EVT-1:0] event_i,
    input  logic               rd_start_i,
    input  logic               rd_end_i,
    output logic [NUM_EVT-1:0] status_o,
    output logic               in_read_o
);
    logic [NUM_EVT-1:0] status_q, held_q, snap_q;
    logic [NUM_EVT-1:0] status_d, held_d;
    logic               in_read_q, clr;

    assign clr = rd_end_i & in_read_q;

    // Next status and held events from clear, held and new events.
    always_comb begin
        status_d = status_q;
        if (clr) status_d = status_q & ~snap_q;
        if (!in_read_q) status_d = status_d | held_q | event_i;
        held_d = in_read_q ? (held_q | event_i) : '0;
    end

    // Track the read window, take the snapshot, update the registers.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            status_q  <= '0;
            held_q    <= '0;
            snap_q    <= '0;
            in_read_q <= 1'b0;
        end else begin
            status_q <= status_d;
            held_q   <= held_d;
            if (rd_start_i && !in_read_q) begin
                in_read_q <= 1'b1;
                snap_q    <= status_q;
            end else if (clr) begin
                in_read_q <= 1'b0;
            end
        end
    end

    assign status_o  = status_q;
    assign in_read_o = in_read_q;

    // R6: every returned bit is clear after the read closes
    a_r6_clear_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !sw_rst_i) |=> ((status_q & $past(snap_q)) == '0));
    // R7: events during an open read are captured in the holding register
    a_r7_hold_events: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read_q && !sw_rst_i && event_i != '0)
            |=> ((held_q & $past(event_i)) == $past(event_i)));
    // R7: the status register does not grow while a read is open
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read_q && !clr && !sw_rst_i && !$past(!in_read_q))
            |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/irq_line_ctrl.sv
// Module irq_line_ctrl
// Drives the active-low interrupt line from the masked status. Lets the
// line go at the first serial-clock falling edge after a status read
// command and holds it released until the read ends. Assumes sclk_i is
// synchronous to clk.
module irq_line_ctrl #(
    parameter int unsigned NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst_i,
    input  logic               sclk_i,
    input  logic               arm_i,
    input  logic               done_i,
    input  logic [NUM_EVT-1:0] status_i,
    input  logic [NUM_EVT-1:0] enable_i,
    output logic               irq_n_o
);
    logic sclk_q, armed_q, release_q, sclk_fall;

    assign sclk_fall = sclk_q & ~sclk_i;

    // Sample the serial clock to find its falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_i;
    end

    // Arm at the read command, release on the first fall, end at read close.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            armed_q   <= 1'b0;
            release_q <= 1'b0;
        end else if (arm_i) begin
            armed_q   <= 1'b1;
            release_q <= 1'b0;
        end else if (done_i) begin
            armed_q   <= 1'b0;
            release_q <= 1'b0;
        end else if (armed_q && sclk_fall) begin
            armed_q   <= 1'b0;
            release_q <= 1'b1;
        end
    end

    // Line is low while any enabled bit is set, unless released.
    always_comb irq_n_o = release_q | ~(|(status_i & enable_i));

    // R8: a falling edge while armed releases the line next cycle
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sclk_fall && !arm_i && !done_i && !sw_rst_i) |=> irq_n_o);
    // R3: with every event masked the line never drops
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |-> irq_n_o);
endmodule

// File: rtl/irq_status_reg.sv
// Module irq_status_reg (top)
// Maskable interrupt status register. It decodes register commands,
// holds the enable register, routes the shared underrun/abort bit and
// ties together edge detection, status latching and the interrupt line.
// Assumes commands arrive as one-cycle strobes from an external serial
// port shifter and that only one status read is open at a time.
module irq_status_reg
    import irq_status_pkg::*;
#(
    parameter int unsigned NUM_EVT    = DEF_NUM_EVT,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned STAT_ADDR  = DEF_STAT_ADDR,
    parameter int unsigned EN_ADDR    = DEF_EN_ADDR,
    parameter int unsigned SHARED_POS = DEF_SHARED_POS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst_i,
    input  logic [NUM_EVT-1:0] cond_i,
    input  logic               alt_cond_i,
    input  logic               sel_alt_i,
    input  logic               sclk_i,
    input  logic               cmd_stb_i,
    input  logic               cmd_rd_i,
    input  logic [ADDR_W-1:0]  cmd_addr_i,
    input  logic [NUM_EVT-1:0] wdata_i,
    input  logic               rd_end_i,
    output logic [NUM_EVT-1:0] rdata_o,
    output logic               irq_n_o
);
    localparam int unsigned     RAW_W  = NUM_EVT + 1;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

    logic [RAW_W-1:0]   raw_rise;
    logic [NUM_EVT-1:0] evt;
    logic [NUM_EVT-1:0] status, enable_q, rdata_q;
    logic               in_read, rd_start, rd_arm, rd_done, en_wr;

    irq_edge_detect #(.WIDTH(RAW_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({alt_cond_i, cond_i}),
        .rise_o  (raw_rise)
    );

    // Route each position; the shared one picks underrun or abort.
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_route
        if (k == SHARED_POS) begin : g_shared
            assign evt[k] = sel_alt_i ? raw_rise[NUM_EVT] : raw_rise[k];
        end else begin : g_plain
            assign evt[k] = raw_rise[k];
        end
    end

    assign rd_start = cmd_stb_i & cmd_rd_i & (cmd_addr_i == A_STAT);
    assign rd_arm   = rd_start & ~in_read;
    assign rd_done  = rd_end_i & in_read;
    assign en_wr    = cmd_stb_i & ~cmd_rd_i & (cmd_addr_i == A_EN);

    irq_event_latch #(.NUM_EVT(NUM_EVT)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst_i   (sw_rst_i),
        .event_i    (evt),
        .rd_start_i (rd_start),
        .rd_end_i   (rd_end_i),
        .status_o   (status),
        .in_read_o  (in_read)
    );

    irq_line_ctrl #(.NUM_EVT(NUM_EVT)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst_i (sw_rst_i),
        .sclk_i   (sclk_i),
        .arm_i    (rd_arm),
        .done_i   (rd_done),
        .status_i (status),
        .enable_i (enable_q),
        .irq_n_o  (irq_n_o)
    );

    // Enable register: cleared by either reset, loaded by a write command.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) enable_q <= '0;
        else if (en_wr)         enable_q <= wdata_i;
    end

    // Read data: capture the addressed register at a read command.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            rdata_q <= '0;
        end else if (cmd_stb_i && cmd_rd_i) begin
            if (cmd_addr_i == A_STAT)    rdata_q <= status;
            else if (cmd_addr_i == A_EN) rdata_q <= enable_q;
        end
    end

    assign rdata_o = rdata_q;

    // R10: software reset leaves every event masked
    a_r10_sw_mask: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> (enable_q == '0));
    // R5: a status read returns the status seen at the command
    a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !sw_rst_i) |=> (rdata_o == $past(status)));
    // R1: after a software reset the line is inactive
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> irq_n_o);
endmodule

// File: tb/sim_irq_status_reg.sv
// Bench sim_irq_status_reg: sweeps every event bit against every enable
// mask, then checks the shared bit, held events, release and resets.
module sim_irq_status_reg;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0, sw_rst = 1'b0;
    logic [N-1:0] cond = '0, wdata = '0;
    logic         alt = 1'b0, sel_alt = 1'b0, sclk = 1'b1;
    logic         cmd_stb = 1'b0, cmd_rd = 1'b0, rd_end = 1'b0;
    logic [2:0]   cmd_addr = '0;
    logic [N-1:0] rdata;
    logic         irq_n;
    int           n_cmp = 0, n_bad = 0;
    logic [N-1:0] v;

    always #5 clk = ~clk;

    irq_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst), .cond_i(cond),
        .alt_cond_i(alt), .sel_alt_i(sel_alt), .sclk_i(sclk),
        .cmd_stb_i(cmd_stb), .cmd_rd_i(cmd_rd), .cmd_addr_i(cmd_addr),
        .wdata_i(wdata), .rd_end_i(rd_end), .rdata_o(rdata), .irq_n_o(irq_n)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_en(input logic [N-1:0] d);
        cmd_stb = 1'b1; cmd_rd = 1'b0; cmd_addr = 3'd6; wdata = d;
        step();
        cmd_stb = 1'b0;
    endtask

    task automatic read_en(output logic [N-1:0] r);
        cmd_stb = 1'b1; cmd_rd = 1'b1; cmd_addr = 3'd6;
        step();
        cmd_stb = 1'b0;
        r = rdata;
    endtask

    // Full status read: command, sample, end strobe.
    task automatic read_stat(output logic [N-1:0] r);
        cmd_stb = 1'b1; cmd_rd = 1'b1; cmd_addr = 3'd7;
        step();
        cmd_stb = 1'b0;
        r = rdata;
        rd_end = 1'b1;
        step();
        rd_end = 1'b0;
    endtask

    task automatic pulse_cond(input int k);
        cond[k] = 1'b1; step(); cond[k] = 1'b0; step();
    endtask

    task automatic pulse_alt();
        alt = 1'b1; step(); alt = 1'b0; step();
    endtask

    task automatic soft_reset();
        sw_rst = 1'b1; step(); sw_rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: power-up state
        chk("R1 irq after reset", 32'(irq_n), 32'd1);
        read_en(v);  chk("R1 enable after reset", 32'(v), 32'd0);
        read_stat(v); chk("R1 status after reset", 32'(v), 32'd0);

        // R2 R3 R4 R5 R6: every bit against every mask
        for (int k = 0; k < N; k++) begin
            for (int m = 0; m < (1 << N); m++) begin
                logic [N-1:0] msk, bit1;
                msk  = N'(m);
                bit1 = N'(1 << k);
                soft_reset();
                write_en(msk);
                pulse_cond(k);
                chk($sformatf("R4 irq bit%0d mask%0h", k, m), 32'(irq_n),
                    32'((msk & bit1) == '0));
                read_stat(v);
                chk($sformatf("R3 status bit%0d mask%0h", k, m), 32'(v), 32'(bit1));
                chk($sformatf("R6 irq cleared bit%0d", k), 32'(irq_n), 32'd1);
            end
        end
        read_stat(v); chk("R6 status empty after clear", 32'(v), 32'd0);
        read_en(v);   chk("R5 enable readback", 32'(v), 32'hf);

        // R10: software reset masks everything
        soft_reset();
        read_en(v); chk("R10 enable cleared", 32'(v), 32'd0);
        pulse_cond(0);
        chk("R10 masked after soft reset", 32'(irq_n), 32'd1);
        read_stat(v); chk("R3 masked bit still recorded", 32'(v), 32'd1);

        // R2: held level sets once
        write_en('1);
        cond[1] = 1'b1; step(); step();
        read_stat(v); chk("R2 first transition", 32'(v), 32'd2);
        step();
        read_stat(v); chk("R2 held level no repeat", 32'(v), 32'd0);
        chk("R2 irq quiet while held", 32'(irq_n), 32'd1);
        cond[1] = 1'b0; step();

        // R9: shared bit selection
        sel_alt = 1'b1;
        pulse_cond(2);
        read_stat(v); chk("R9 abort ignored when underrun selected", 32'(v), 32'd0);
        pulse_alt();
        read_stat(v); chk("R9 underrun on shared bit", 32'(v), 32'd4);
        sel_alt = 1'b0;
        pulse_alt();
        read_stat(v); chk("R9 underrun ignored when abort selected", 32'(v), 32'd0);
        pulse_cond(2);
        read_stat(v); chk("R9 abort on shared bit", 32'(v), 32'd4);

        // R6: event in the command cycle survives the clear
        pulse_cond(0);
        cmd_stb = 1'b1; cmd_rd = 1'b1; cmd_addr = 3'd7; cond[3] = 1'b1;
        step();
        cmd_stb = 1'b0; cond[3] = 1'b0;
        chk("R5 returned snapshot", 32'(rdata), 32'd1);
        rd_end = 1'b1; step(); rd_end = 1'b0;
        read_stat(v); chk("R6 unreturned bit kept", 32'(v), 32'd8);

        // R7 R8: release at SCLK fall and held event
        soft_reset();
        write_en(4'b0011);
        pulse_cond(0);
        chk("R4 irq active", 32'(irq_n), 32'd0);
        cmd_stb = 1'b1; cmd_rd = 1'b1; cmd_addr = 3'd7;
        step();
        cmd_stb = 1'b0;
        chk("R8 not released before SCLK fall", 32'(irq_n), 32'd0);
        sclk = 1'b0; step();
        chk("R8 released at SCLK fall", 32'(irq_n), 32'd1);
        cond[1] = 1'b1; step(); cond[1] = 1'b0;
        chk("R7 held event not shown", 32'(irq_n), 32'd1);
        rd_end = 1'b1; step(); rd_end = 1'b0;
        chk("R7 status cleared at read end", 32'(irq_n), 32'd1);
        step();
        chk("R7 held event applied after read", 32'(irq_n), 32'd0);
        sclk = 1'b1; step();
        read_stat(v); chk("R7 held event value", 32'(v), 32'd2);

        // R1: power-up reset clears enables
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        read_en(v); chk("R1 enable after power reset", 32'(v), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule